// File: doc/BRIEF.md
# Bit-Test Branch and Skip Decision Unit

This unit resolves control flow for a small 8-bit processor core. It handles two bit-test conditional branches, one of which also clears the tested bit when it branches, and six flag-driven skips that cancel the execution of the following instruction. The decoder presents one operation with a valid strobe. The unit samples the operation, models its execution latency, and then reports the next program counter, whether a branch was taken, a request to clear the tested bit, and whether the instruction it just retired was a cancelled one.

Every operation occupies a fixed number of cycles after it is accepted. `busy` is high for all of these cycles except the last. In the last cycle `done` is high and the results are presented. A new operation can be accepted in that same last cycle. Operations that are neither branches nor skips pass through in one cycle and advance the program counter by the length the decoder supplies.

Top module: `bitbr_ctrl`

## Requirements
- R1: Opcode 1 (branch-on-zero) is taken when `tst_bit` is 0. The taken target is `pc_in` plus the instruction length plus the sign-extended `disp_in`, computed modulo 2^20.
- R2: Opcode 2 (branch-on-one-and-clear) is taken when `tst_bit` is 1.
- R3: A taken opcode 2 raises `bclr_req` for exactly the `done` cycle, with `bclr_idx` equal to the sampled `tst_idx`. No other case raises `bclr_req`.
- R4: A branch that is not taken reports `pc_in` plus the instruction length with `br_taken` low.
- R5: The branch length depends on `op_form`. Form 0 (accumulator bit) and form 1 (indirect bit) are 3 bytes long. Forms 2 (short direct), 3 (special register), 4 (status word) and 5 (segment-prefixed indirect) are 4 bytes long.
- R6: A branch takes 3 cycles when not taken and 5 cycles when taken. Form 5 takes 4 and 6 cycles. For an operation of L cycles, `done` is high in the L-th cycle after the accepting edge, and `busy` is high in the L-1 cycles before it.
- R7: `op_valid` is ignored while `busy` is high.
- R8: The skip opcodes are: 3 skips when CY=1, 4 when CY=0, 5 when Z=1, 6 when Z=0, 7 when (Z|CY)=0, and 8 when (Z|CY)=1. A skip is 2 bytes long, takes 1 cycle and never reports `br_taken`.
- R9: After a skip whose condition holds, the next accepted operation is cancelled. It completes in 1 cycle with `skip_next` high in its `done` cycle, `pc_next` equal to its `pc_in` plus its length, and `br_taken` and `bclr_req` low.
- R10: A cancelled skip does not cancel the operation that follows it, so `skip_next` never marks two consecutive operations.
- R11: Opcode 0 and opcodes 9 to 15 complete in 1 cycle with `pc_next` = `pc_in` + `op_len`.
- R12: During and after reset, before any operation, `busy`, `done`, `br_taken`, `bclr_req` and `skip_next` are low and no cancellation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R1, R2, R8, R11) |
| op_form | input | 3 | Bit-operand addressing form (see R5) |
| op_len | input | 3 | Length in bytes of a plain operation |
| pc_in | input | 20 | Address of the operation |
| disp_in | input | 8 | Signed branch displacement |
| tst_bit | input | 1 | Value of the tested bit |
| tst_idx | input | 3 | Index of the tested bit |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| busy | output | 1 | Operation still running; input not accepted |
| done | output | 1 | Last cycle of an operation; results valid |
| pc_next | output | 20 | Next program counter |
| br_taken | output | 1 | Branch taken (with done) |
| bclr_req | output | 1 | Clear-bit write request (one cycle) |
| bclr_idx | output | 3 | Index of the bit to clear |
| skip_next | output | 1 | Retired operation was cancelled |

## Verification
A pending cancellation and a branch can meet in the same decision. The case that matters most is when a skip whose condition holds is followed directly by a branch-on-one-and-clear whose tested bit is 1, or by another skip whose condition holds. The bench issues these pairs back to back. It checks that the cancellation wins: the branch completes in one cycle with no taken flag and no clear request, and the cancelled skip does not arm a second cancellation. A further case puts an accepted operation's `done` cycle next to a stream of offers held on `op_valid` while `busy` is high. None of those offers may be taken.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;

  typedef enum logic [3:0] {
    OPC_PLAIN      = 4'd0,
    OPC_BR_ZERO    = 4'd1,
    OPC_BR_ONE_CLR = 4'd2,
    OPC_SK_CY      = 4'd3,
    OPC_SK_NCY     = 4'd4,
    OPC_SK_Z       = 4'd5,
    OPC_SK_NZ      = 4'd6,
    OPC_SK_HI      = 4'd7,
    OPC_SK_NHI     = 4'd8
  } opc_e;

  typedef enum logic [2:0] {
    FRM_ACC  = 3'd0,
    FRM_IND  = 3'd1,
    FRM_SDIR = 3'd2,
    FRM_SFR  = 3'd3,
    FRM_PSW  = 3'd4,
    FRM_SEG  = 3'd5
  } frm_e;

  typedef struct packed {
    logic is_br;
    logic is_skip;
    logic taken;
    logic clr;
    logic arm;
  } dec_t;

endpackage

// File: rtl/bitbr_cond.sv
module bitbr_cond
  import bitbr_pkg::*;
(
  input  logic [3:0] opc,
  input  logic       bit_val,
  input  logic       cy,
  input  logic       z,
  input  logic       suppress,
  output dec_t       dec
);

  logic hit;

  always_comb begin
    dec = '0;
    hit = 1'b0;
    case (opc)
      OPC_BR_ZERO: begin
        dec.is_br = 1'b1;
        hit       = ~bit_val;
      end
      OPC_BR_ONE_CLR: begin
        dec.is_br = 1'b1;
        hit       = bit_val;
      end
      OPC_SK_CY:  begin dec.is_skip = 1'b1; hit = cy;         end
      OPC_SK_NCY: begin dec.is_skip = 1'b1; hit = ~cy;        end
      OPC_SK_Z:   begin dec.is_skip = 1'b1; hit = z;          end
      OPC_SK_NZ:  begin dec.is_skip = 1'b1; hit = ~z;         end
      OPC_SK_HI:  begin dec.is_skip = 1'b1; hit = ~(z | cy);  end
      OPC_SK_NHI: begin dec.is_skip = 1'b1; hit = z | cy;     end
      default:    hit = 1'b0;
    endcase
    dec.taken = dec.is_br & hit & ~suppress;
    dec.clr   = dec.taken & (opc == OPC_BR_ONE_CLR);
    dec.arm   = dec.is_skip & hit & ~suppress;
  end

endmodule

// File: rtl/bitbr_target.sv
module bitbr_target #(
  parameter int unsigned PC_W   = 20,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   target
);

  localparam int unsigned SEXT_W = PC_W - DISP_W;
  localparam int unsigned ZEXT_W = PC_W - LEN_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] len_ext;

  always_comb begin
    disp_ext = {{SEXT_W{disp[DISP_W-1]}}, disp};
    len_ext  = {{ZEXT_W{1'b0}}, len};
    target   = pc + len_ext + (taken ? disp_ext : '0);
  end

endmodule

// File: rtl/bitbr_timer.sv
module bitbr_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] lat,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = lat;
    end else if (rem_q != '0) begin
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

  assign busy = rem_q > CNT_W'(1);
  assign last = rem_q == CNT_W'(1);

endmodule

// File: rtl/bitbr_ctrl.sv
module bitbr_ctrl
  import bitbr_pkg::*;
#(
  parameter int unsigned PC_W      = 20,
  parameter int unsigned DISP_W    = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned LEN_W     = 3,
  parameter int unsigned LEN_SHORT = 3,
  parameter int unsigned LEN_LONG  = 4,
  parameter int unsigned LEN_SKIP  = 2,
  parameter int unsigned LAT_NT    = 3,
  parameter int unsigned LAT_T     = 5,
  parameter int unsigned SEG_EXTRA = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [2:0]        op_form,
  input  logic [LEN_W-1:0]  op_len,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp_in,
  input  logic              tst_bit,
  input  logic [IDX_W-1:0]  tst_idx,
  input  logic              flag_cy,
  input  logic              flag_z,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   pc_next,
  output logic              br_taken,
  output logic              bclr_req,
  output logic [IDX_W-1:0]  bclr_idx,
  output logic              skip_next
);

  localparam int unsigned LAT_MAX = LAT_T + SEG_EXTRA;
  localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic             accept;
  logic             last;
  logic             pend_q, pend_d;
  dec_t             dec;
  logic [LEN_W-1:0] len_sel;
  logic [PC_W-1:0]  target;
  logic [CNT_W-1:0] lat_sel;
  logic             seg_form;

  logic [PC_W-1:0]  pc_q, pc_d;
  logic             taken_q, taken_d;
  logic             clr_q, clr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             supp_q, supp_d;

  assign accept = op_valid & ~busy;

  bitbr_cond u_cond (
    .opc      (op_code),
    .bit_val  (tst_bit),
    .cy       (flag_cy),
    .z        (flag_z),
    .suppress (pend_q),
    .dec      (dec)
  );

  always_comb begin
    seg_form = (op_form == FRM_SEG);
    if (dec.is_br) begin
      len_sel = ((op_form == FRM_ACC) || (op_form == FRM_IND)) ?
                LEN_W'(LEN_SHORT) : LEN_W'(LEN_LONG);
    end else if (dec.is_skip) begin
      len_sel = LEN_W'(LEN_SKIP);
    end else begin
      len_sel = op_len;
    end

    if (dec.is_br && !pend_q) begin
      lat_sel = dec.taken ? CNT_W'(LAT_T) : CNT_W'(LAT_NT);
      if (seg_form) begin
        lat_sel = lat_sel + CNT_W'(SEG_EXTRA);
      end
    end else begin
      lat_sel = CNT_W'(1);
    end
  end

  bitbr_target #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .LEN_W  (LEN_W)
  ) u_target (
    .pc     (pc_in),
    .len    (len_sel),
    .disp   (disp_in),
    .taken  (dec.taken),
    .target (target)
  );

  bitbr_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (accept),
    .lat   (lat_sel),
    .busy  (busy),
    .last  (last)
  );

  // next state of the result registers
  always_comb begin
    pc_d    = pc_q;
    taken_d = taken_q;
    clr_d   = clr_q;
    idx_d   = idx_q;
    supp_d  = supp_q;
    pend_d  = pend_q;
    if (accept) begin
      pc_d    = target;
      taken_d = dec.taken;
      clr_d   = dec.clr;
      idx_d   = tst_idx;
      supp_d  = pend_q;
      pend_d  = dec.arm;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
      clr_q   <= 1'b0;
      idx_q   <= '0;
      supp_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      taken_q <= taken_d;
      clr_q   <= clr_d;
      idx_q   <= idx_d;
      supp_q  <= supp_d;
      pend_q  <= pend_d;
    end
  end

  assign done      = last;
  assign pc_next   = pc_q;
  assign br_taken  = last & taken_q;
  assign bclr_req  = last & clr_q;
  assign bclr_idx  = idx_q;
  assign skip_next = last & supp_q;

endmodule

// File: rtl/bitbr_ctrl_chk.sv
module bitbr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic br_taken,
  input logic bclr_req,
  input logic skip_next
);

  logic prev_skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_skip_q <= 1'b0;
    end else if (done) begin
      prev_skip_q <= skip_next;
    end
  end

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R6
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
  AST_TAKEN_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> done); // R1
  AST_CLR_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    bclr_req |-> br_taken); // R2
  AST_CLR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bclr_req |=> !bclr_req); // R3
  AST_CANCEL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> (!br_taken && !bclr_req)); // R9
  AST_CANCEL_NOT_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && skip_next) |-> !prev_skip_q); // R10

endmodule

bind bitbr_ctrl bitbr_ctrl_chk u_chk (.*);

// File: tb/bitbr_ctrl_bench.sv
`timescale 1ns/1ps
module bitbr_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [2:0]  op_form;
  logic [2:0]  op_len;
  logic [19:0] pc_in;
  logic [7:0]  disp_in;
  logic        tst_bit;
  logic [2:0]  tst_idx;
  logic        flag_cy;
  logic        flag_z;
  logic        busy;
  logic        done;
  logic [19:0] pc_next;
  logic        br_taken;
  logic        bclr_req;
  logic [2:0]  bclr_idx;
  logic        skip_next;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit pend = 0;  // model: cancellation pending

  bitbr_ctrl u_bitbr_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_form(op_form), .op_len(op_len), .pc_in(pc_in), .disp_in(disp_in),
    .tst_bit(tst_bit), .tst_idx(tst_idx), .flag_cy(flag_cy), .flag_z(flag_z),
    .busy(busy), .done(done), .pc_next(pc_next), .br_taken(br_taken),
    .bclr_req(bclr_req), .bclr_idx(bclr_idx), .skip_next(skip_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference for one operation
  task automatic run_op(input int op, input int form, input int len_in,
                        input int pc, input int disp, input bit bv,
                        input int idx, input bit cy, input bit z,
                        input bit junk, input string req);
    bit is_br, is_sk, hit, sup, tk, clr;
    int len, lat, exp_pc;
    is_br = (op == 1) || (op == 2);
    is_sk = (op >= 3) && (op <= 8);
    case (op)
      1: hit = !bv;
      2: hit = bv;
      3: hit = cy;
      4: hit = !cy;
      5: hit = z;
      6: hit = !z;
      7: hit = !(z || cy);
      8: hit = z || cy;
      default: hit = 0;
    endcase
    if (is_br) len = (form <= 1) ? 3 : 4;
    else if (is_sk) len = 2;
    else len = len_in;
    sup = pend;
    tk  = is_br && hit && !sup;
    clr = tk && (op == 2);
    if (is_br && !sup) lat = (tk ? 5 : 3) + ((form == 5) ? 1 : 0);
    else lat = 1;
    exp_pc = pc + len;
    if (tk) exp_pc = exp_pc + ((disp >= 128) ? disp - 256 : disp);
    exp_pc = exp_pc & 32'hFFFFF;
    pend = is_sk && hit && !sup;

    op_valid = 1'b1;
    op_code  = 4'(op);
    op_form  = 3'(form);
    op_len   = 3'(len_in);
    pc_in    = 20'(pc);
    disp_in  = 8'(disp);
    tst_bit  = bv;
    tst_idx  = 3'(idx);
    flag_cy  = cy;
    flag_z   = z;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (junk && i < lat) begin
        // offer a would-be-taken clear branch while busy (R7)
        op_valid = 1'b1;
        op_code  = 4'd2;
        tst_bit  = 1'b1;
        pc_in    = 20'h0;
      end else begin
        op_valid = 1'b0;
      end
      chk(req, $sformatf("busy c%0d", i), longint'(busy), longint'(i < lat));
      chk(req, $sformatf("done c%0d", i), longint'(done), longint'(i == lat));
      if (i == lat) begin
        chk(req, "pc_next", longint'(pc_next), longint'(exp_pc));
        chk(req, "br_taken", longint'(br_taken), longint'(tk));
        chk(req, "bclr_req", longint'(bclr_req), longint'(clr));
        if (clr) chk(req, "bclr_idx", longint'(bclr_idx), longint'(idx));
        chk(req, "skip_next", longint'(skip_next), longint'(sup));
      end else begin
        chk(req, "bclr_req early", longint'(bclr_req), 0);
      end
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk(req, "idle done", longint'(done), 0);
    chk(req, "idle busy", longint'(busy), 0);
  endtask

  initial begin
    op_valid = 0; op_code = 0; op_form = 0; op_len = 1; pc_in = 0;
    disp_in = 0; tst_bit = 0; tst_idx = 0; flag_cy = 0; flag_z = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "busy in reset", longint'(busy), 0);
    chk("R12", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "busy", longint'(busy), 0);
    chk("R12", "done", longint'(done), 0);
    chk("R12", "br_taken", longint'(br_taken), 0);
    chk("R12", "bclr_req", longint'(bclr_req), 0);
    chk("R12", "skip_next", longint'(skip_next), 0);

    // R11: plain and unused opcodes
    run_op(0, 0, 1, 'h100, 0, 0, 0, 0, 0, 0, "R11");
    run_op(12, 0, 3, 'h200, 'h40, 0, 0, 1, 1, 0, "R11");
    // R1/R5: branch-on-zero taken, short and long forms
    run_op(1, 0, 0, 'h1000, 'h10, 0, 0, 0, 0, 0, "R1");
    run_op(1, 1, 0, 'h1000, 'h80, 0, 0, 0, 0, 0, "R1");
    run_op(1, 3, 0, 'hFFFFE, 'h7F, 0, 0, 0, 0, 0, "R1");
    run_op(1, 0, 0, 'h00002, 'hF0, 0, 0, 0, 0, 0, "R1");
    // R4/R5: not taken
    run_op(1, 2, 0, 'h3000, 'h22, 1, 0, 0, 0, 0, "R4");
    run_op(1, 1, 0, 'h3000, 'h22, 1, 0, 0, 0, 0, "R5");
    // R2/R3: branch-on-one-and-clear
    run_op(2, 4, 0, 'h4000, 'h08, 1, 5, 0, 0, 0, "R3");
    run_op(2, 1, 0, 'h4000, 'h08, 0, 5, 0, 0, 0, "R2");
    run_op(2, 2, 0, 'h4100, 'hFE, 1, 7, 0, 0, 0, "R2");
    // R6: segment-prefixed form latencies
    run_op(1, 5, 0, 'h5000, 'h04, 0, 0, 0, 0, 0, "R6");
    run_op(1, 5, 0, 'h5000, 'h04, 1, 0, 0, 0, 0, "R6");
    run_op(2, 5, 0, 'h5000, 'h04, 1, 2, 0, 0, 0, "R6");
    // R7: offers held while busy are ignored
    run_op(2, 0, 0, 'h6000, 'h10, 1, 3, 0, 0, 1, "R7");
    idle_check("R7");
    run_op(1, 5, 0, 'h6100, 'h10, 1, 0, 0, 0, 1, "R7");
    idle_check("R7");
    // R8/R9: every skip under every flag pair, then a plain op
    for (int op = 3; op <= 8; op++) begin
      for (int f = 0; f < 4; f++) begin
        run_op(op, 0, 0, 'h7000 + op * 16, 0, 0, 0, f[0], f[1], 0, "R8");
        run_op(0, 0, 2, 'h7800, 0, 0, 0, 0, 0, 0, "R9");
      end
    end
    // R9: skip hit meets a clear-branch that would be taken
    run_op(3, 0, 0, 'h8000, 0, 0, 0, 1, 0, 0, "R9");
    run_op(2, 4, 0, 'h8002, 'h20, 1, 6, 0, 0, 0, "R9");
    run_op(5, 0, 0, 'h8100, 0, 0, 0, 0, 1, 0, "R9");
    run_op(1, 5, 0, 'h8102, 'h20, 0, 0, 0, 0, 0, "R9");
    // R10: cancelled skip does not chain
    run_op(8, 0, 0, 'h9000, 0, 0, 0, 1, 1, 0, "R10");
    run_op(8, 0, 0, 'h9002, 0, 0, 0, 1, 1, 0, "R10");
    run_op(0, 0, 1, 'h9004, 0, 0, 0, 0, 0, 0, "R10");
    run_op(1, 0, 0, 'h9010, 'h04, 0, 0, 0, 0, 0, "R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule